// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block serialises one packet onto the differential pair of a low-speed USB link. A single start pulse with a total byte count starts it. The block then drives the bus for the length of the packet and releases it afterwards. It adds the sync byte itself, so the host logic supplies only the bytes that follow it. These bytes are fetched one at a time through a request pulse. Every bit occupies a fixed cell of system clocks. Data leave least significant bit first, NRZI coded and bit-stuffed.

Around the packet the block puts one J cell to claim the bus, and it ends the packet with a two-cell SE0 and one J cell before the drivers are turned off. A one-cycle done pulse marks the release. A handshake reply such as an acknowledge is a two-byte packet: sync plus one identifier byte.

Top module: `usb_ls_tx`

## Requirements
- R1: Every line cell, whether J, data, stuffed, SE0 or closing J, lasts exactly CLKS_PER_BIT (default 11) clocks.
- R2: A start pulse is accepted only while busy_o is low. busy_o rises on the clock edge that samples the start and stays high until the release edge. A start seen while busy_o is high has no effect on the packet in flight.
- R3: len_i is latched at start and gives the total byte count including the sync byte. Values below 2 are treated as 2, and values above MAX_BYTES (default 12) are treated as MAX_BYTES.
- R4: During the first cell after start, oe_o is high and the line shows J (dp_o=0, dm_o=1).
- R5: The first byte sent is 0x80, least significant bit first. It is followed by len-1 bytes from data_i, each also least significant bit first.
- R6: NRZI coding applies. A 0 bit swaps the line between J (dp_o=0, dm_o=1) and K (dp_o=1, dm_o=0). A 1 bit keeps the previous level.
- R7: After six consecutive 1 bits, one extra line swap cell is inserted before the next bit. The run counts across byte boundaries and also after the final data bit.
- R8: After the last data or stuffed cell, both lines are low with oe_o high for two cells, then J for one cell. After that oe_o, dp_o and dm_o are all 0.
- R9: done_o is a one-cycle pulse on the same edge that drops oe_o and busy_o.
- R10: data_req_o pulses for one cycle at the start of the cell carrying bit 6 of every byte that has a successor. data_i must then hold that successor until the next request or the end of the packet.
- R11: After reset, oe_o, dp_o, dm_o, busy_o, done_o and data_req_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| len_i | input | LEN_W | Total byte count including sync |
| data_i | input | 8 | Next packet byte, valid after a request |
| data_req_o | output | 1 | Request for the next byte |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-cycle pulse at bus release |
| oe_o | output | 1 | Line driver enable |
| dp_o | output | 1 | D+ level |
| dm_o | output | 1 | D- level |

## Verification
The bench builds the block with its defaults: 11 clocks per cell, at most 12 bytes, and a 4-bit length field. With a 4-bit length field, values such as 1 and 15 can be driven, so both clamping limits are exercised. A 12-byte packet fits comfortably within the run. Data patterns are chosen so that stuffing occurs inside a byte, across a byte boundary and directly before the end of packet. A second start is injected in the middle of a packet to show that it is ignored.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;

  typedef enum logic [2:0] {
    LC_HOLD,
    LC_J,
    LC_BIT,
    LC_SE0,
    LC_OFF
  } line_cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_EOP,
    ST_TAIL
  } tx_state_t;

  localparam logic [7:0] SYNC_BYTE = 8'h80;

endpackage

// File: rtl/usb_ls_cell_timer.sv
module usb_ls_cell_timer #(
  parameter int CLKS_PER_BIT = 11,
  localparam int CNT_W = $clog2(CLKS_PER_BIT)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_BIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
    end
  end

  assign tick_o = run_i && (cnt_q == LAST);

  // R1: cell counter never leaves its range and ticks are isolated
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

endmodule

// File: rtl/usb_ls_tx_serializer.sv
module usb_ls_tx_serializer
  import usb_ls_tx_pkg::*;
#(
  parameter int MAX_BYTES = 12,
  parameter int STUFF_RUN = 6,
  localparam int LEN_W  = $clog2(MAX_BYTES + 1),
  localparam int ONES_W = $clog2(STUFF_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             advance_i,
  input  logic [7:0]       data_i,
  output logic             avail_o,
  output logic             bit_o,
  output logic             req_o
);

  logic [7:0]        shift_q;
  logic [2:0]        bidx_q;
  logic [LEN_W-1:0]  rem_q;
  logic [ONES_W-1:0] ones_q;
  logic [ONES_W-1:0] ones_nxt;
  logic              stuff_q;
  logic              drained_q;
  logic [LEN_W-1:0]  len_c;

  always_comb begin
    if (len_i < LEN_W'(2))
      len_c = LEN_W'(2);
    else if (len_i > LEN_W'(MAX_BYTES))
      len_c = LEN_W'(MAX_BYTES);
    else
      len_c = len_i;
  end

  assign avail_o  = !drained_q || stuff_q;
  assign bit_o    = stuff_q ? 1'b0 : shift_q[0];
  assign ones_nxt = shift_q[0] ? ones_q + ONES_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q   <= '0;
      bidx_q    <= '0;
      rem_q     <= '0;
      ones_q    <= '0;
      stuff_q   <= 1'b0;
      drained_q <= 1'b1;
      req_o     <= 1'b0;
    end else begin
      req_o <= 1'b0;
      if (load_i) begin
        shift_q   <= SYNC_BYTE;
        bidx_q    <= '0;
        rem_q     <= len_c - LEN_W'(1);
        ones_q    <= '0;
        stuff_q   <= 1'b0;
        drained_q <= 1'b0;
      end else if (advance_i && avail_o) begin
        if (stuff_q) begin
          stuff_q <= 1'b0;
          ones_q  <= '0;
        end else begin
          if (ones_nxt == ONES_W'(STUFF_RUN)) begin
            stuff_q <= 1'b1;
            ones_q  <= '0;
          end else begin
            ones_q <= ones_nxt;
          end
          req_o <= (bidx_q == 3'd6) && (rem_q != '0);
          if (bidx_q == 3'd7) begin
            bidx_q <= '0;
            if (rem_q != '0) begin
              shift_q <= data_i;
              rem_q   <= rem_q - LEN_W'(1);
            end else begin
              drained_q <= 1'b1;
            end
          end else begin
            shift_q <= {1'b0, shift_q[7:1]};
            bidx_q  <= bidx_q + 3'd1;
          end
        end
      end
    end
  end

  // R7: the run of ones is cleared before it can exceed the stuffing limit
  assert_ones_bound_R7: assert property (@(posedge clk) disable iff (rst)
    ones_q < ONES_W'(STUFF_RUN));
  // R10: byte requests are single-cycle pulses
  assert_req_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    req_o |=> !req_o);

endmodule

// File: rtl/usb_ls_line_drv.sv
module usb_ls_line_drv
  import usb_ls_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  line_cmd_t cmd_i,
  input  logic      bit_i,
  output logic      oe_o,
  output logic      dp_o,
  output logic      dm_o
);

  logic level_q;   // 1 = J, 0 = K
  logic level_nxt;

  assign level_nxt = bit_i ? level_q : ~level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= 1'b1;
      oe_o    <= 1'b0;
      dp_o    <= 1'b0;
      dm_o    <= 1'b0;
    end else begin
      unique case (cmd_i)
        LC_J: begin
          level_q <= 1'b1;
          oe_o    <= 1'b1;
          dp_o    <= 1'b0;
          dm_o    <= 1'b1;
        end
        LC_BIT: begin
          level_q <= level_nxt;
          dp_o    <= ~level_nxt;
          dm_o    <= level_nxt;
        end
        LC_SE0: begin
          dp_o <= 1'b0;
          dm_o <= 1'b0;
        end
        LC_OFF: begin
          level_q <= 1'b1;
          oe_o    <= 1'b0;
          dp_o    <= 1'b0;
          dm_o    <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // R6: both lines are never high together
  assert_no_se1_R6: assert property (@(posedge clk) disable iff (rst)
    !(dp_o && dm_o));
  // R8: a released bus is quiet
  assert_released_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !oe_o |-> (!dp_o && !dm_o));

endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
  import usb_ls_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 11,
  parameter int MAX_BYTES    = 12,
  parameter int STUFF_RUN    = 6,
  parameter int EOP_CELLS    = 2,
  localparam int LEN_W = $clog2(MAX_BYTES + 1),
  localparam int EOP_W = (EOP_CELLS > 1) ? $clog2(EOP_CELLS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       data_i,
  output logic             data_req_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             oe_o,
  output logic             dp_o,
  output logic             dm_o
);

  tx_state_t        state_q, state_d;
  logic [EOP_W-1:0] eop_q;
  line_cmd_t        cmd;
  logic             tick;
  logic             accept;
  logic             ser_adv;
  logic             ser_avail;
  logic             ser_bit;
  logic             to_eop;
  logic             release_now;

  assign accept = start_i && (state_q == ST_IDLE);
  assign busy_o = (state_q != ST_IDLE);

  always_comb begin
    state_d     = state_q;
    cmd         = LC_HOLD;
    ser_adv     = 1'b0;
    to_eop      = 1'b0;
    release_now = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_PRE;
          cmd     = LC_J;
        end
      end
      ST_PRE, ST_DATA: begin
        if (tick) begin
          if (ser_avail) begin
            state_d = ST_DATA;
            cmd     = LC_BIT;
            ser_adv = 1'b1;
          end else begin
            state_d = ST_EOP;
            cmd     = LC_SE0;
            to_eop  = 1'b1;
          end
        end
      end
      ST_EOP: begin
        if (tick && eop_q == EOP_W'(EOP_CELLS - 1)) begin
          state_d = ST_TAIL;
          cmd     = LC_J;
        end
      end
      ST_TAIL: begin
        if (tick) begin
          state_d     = ST_IDLE;
          cmd         = LC_OFF;
          release_now = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      eop_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= release_now;
      if (to_eop)
        eop_q <= '0;
      else if (state_q == ST_EOP && tick)
        eop_q <= eop_q + EOP_W'(1);
    end
  end

  usb_ls_cell_timer #(
    .CLKS_PER_BIT(CLKS_PER_BIT)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear_i(accept),
    .run_i  (busy_o),
    .tick_o (tick)
  );

  usb_ls_tx_serializer #(
    .MAX_BYTES(MAX_BYTES),
    .STUFF_RUN(STUFF_RUN)
  ) u_ser (
    .clk      (clk),
    .rst      (rst),
    .load_i   (accept),
    .len_i    (len_i),
    .advance_i(ser_adv),
    .data_i   (data_i),
    .avail_o  (ser_avail),
    .bit_o    (ser_bit),
    .req_o    (data_req_o)
  );

  usb_ls_line_drv u_line (
    .clk  (clk),
    .rst  (rst),
    .cmd_i(cmd),
    .bit_i(ser_bit),
    .oe_o (oe_o),
    .dp_o (dp_o),
    .dm_o (dm_o)
  );

  // R2: the drivers are enabled exactly while a packet is in flight
  assert_oe_window_R2: assert property (@(posedge clk) disable iff (rst)
    oe_o == busy_o);
  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));
  // R9: done is a lone pulse coinciding with release
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_done_at_release_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);
  // R10: requests only occur while a packet is in flight
  assert_req_in_packet_R10: assert property (@(posedge clk) disable iff (rst)
    data_req_o |-> busy_o);

endmodule

// File: tb/usb_ls_tx_bench.sv
module usb_ls_tx_bench;
  localparam int CPB  = 11;
  localparam int MAXB = 12;
  localparam int LW   = $clog2(MAXB + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [LW-1:0] len_i = '0;
  logic [7:0]    data_i = '0;
  logic          data_req_o, busy_o, done_o, oe_o, dp_o, dm_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  logic [7:0] d [0:15];
  int exp_cell[$];   // 0 = J, 1 = K, 2 = SE0
  int req_cell[$];

  always #4 clk = ~clk;

  usb_ls_tx u_usb_ls_tx (
    .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i), .data_i(data_i),
    .data_req_o(data_req_o), .busy_o(busy_o), .done_o(done_o),
    .oe_o(oe_o), .dp_o(dp_o), .dm_o(dm_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // Behavioural line model: sync + data, NRZI, stuffing (R5, R6, R7), EOP (R8)
  task automatic build(input int total);
    bit level = 1'b1;
    int ones = 0;
    logic [7:0] by;
    exp_cell.delete();
    req_cell.delete();
    exp_cell.push_back(0);
    for (int bi = 0; bi < total; bi++) begin
      by = (bi == 0) ? 8'h80 : d[bi-1];
      for (int i = 0; i < 8; i++) begin
        if (!by[i]) begin level = ~level; ones = 0; end
        else ones++;
        exp_cell.push_back(level ? 0 : 1);
        if (i == 6 && bi < total - 1) req_cell.push_back(exp_cell.size() - 1);
        if (ones == 6) begin
          level = ~level;
          ones = 0;
          exp_cell.push_back(level ? 0 : 1);
        end
      end
    end
    exp_cell.push_back(2);
    exp_cell.push_back(2);
    exp_cell.push_back(0);
  endtask

  task automatic run_pkt(input string tag, input int len_field, input int total, input int poke_at);
    int k = 0;
    int last;
    int c;
    bit e_req;
    logic [4:0] ev, av;
    string where;
    build(total);
    last = exp_cell.size() * CPB;   // R1: every cell spans CPB clocks
    @(negedge clk);
    start_i = 1'b1;
    len_i   = LW'(len_field);
    for (int n = 0; n <= last + 1; n++) begin
      @(negedge clk);
      start_i = (n == poke_at);
      if (n == poke_at) len_i = LW'(2);
      if (n < last) begin
        c = exp_cell[n / CPB];
        ev = {1'b1, c == 1, c == 0, 1'b1, 1'b0};
        if (n < CPB) where = "R4";
        else if (c == 2 || n >= last - CPB) where = "R8";
        else where = "R6";
      end else begin
        ev = {4'b0000, n == last};
        where = "R9";
      end
      av = {oe_o, dp_o, dm_o, busy_o, done_o};
      chk(av == ev, {tag, " ", where, " line/busy/done"}, av, ev);
      e_req = 1'b0;
      if (n < last && n % CPB == 0)
        foreach (req_cell[j]) if (req_cell[j] == n / CPB) e_req = 1'b1;
      chk(data_req_o == e_req, {tag, " R10 request"}, data_req_o, e_req);
      if (data_req_o && k < 15) begin
        data_i = d[k];
        k++;
      end
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk({oe_o, dp_o, dm_o, busy_o, done_o, data_req_o} == 6'b0, "R11 reset",
        {oe_o, dp_o, dm_o, busy_o, done_o, data_req_o}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    d[0] = 8'hD2;
    run_pkt("R5 handshake", 2, 2, -1);

    d[0] = 8'hFF; d[1] = 8'hFF; d[2] = 8'h3F;
    run_pkt("R7 cross-byte stuff", 4, 4, -1);

    d[0] = 8'h00; d[1] = 8'hFC;
    run_pkt("R7 trailing stuff", 3, 3, -1);

    for (int i = 0; i < 11; i++) d[i] = 8'(i * 37 + 5);
    run_pkt("R1 R3 max length", 12, 12, -1);

    d[0] = 8'h5A;
    run_pkt("R3 clamp low", 1, 2, -1);

    for (int i = 0; i < 11; i++) d[i] = 8'(8'hF0 ^ (i * 13));
    run_pkt("R3 clamp high", 15, 12, -1);

    d[0] = 8'h55; d[1] = 8'hAA; d[2] = 8'h7E;
    run_pkt("R2 start ignored", 4, 4, 40);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule